// File: doc/BRIEF.md
# Vertical Blank Flag and NMI Generator

This block tracks the vertical blank interval of a video processor. It watches the current scanline and dot position and raises a vertical blank flag when the frame enters blanking. It lowers the flag when the pre-render line begins. The flag is readable by the CPU as the top bit of the status register. The block also drives a level-sensitive non-maskable interrupt request toward the CPU. That request is high whenever the flag and the CPU-controlled NMI enable bit are both set.

Interrupt enabling is tied to the control register write path. The block keeps only the enable bit of that register. It sees every write strobe, together with the value of bit 7. Because the request is a level, the CPU detects a new interrupt on each low-to-high transition. Turning the enable off and on again during blanking therefore produces another interrupt. This works only while the flag is still set. A status read clears the flag and ends that possibility until the next frame.

Positions are sampled on the clock edge and all state is registered. Outputs change in the cycle after the stimulus that causes them. The one exception is the status read data, which shows the flag as it stands in the read cycle itself.

Top module: `vblank_nmi_top`

## Requirements
- R1: When the inputs present line SET_LINE (default 241) and dot EDGE_DOT (default 1) at a clock edge, `vblank_o` is 1 after that edge; at any earlier position of the frame it stays 0.
- R2: `nmi_req_o` is 1 exactly when the vertical blank flag and the stored enable bit are both 1; with enable already 1, it rises in the same cycle as the flag.
- R3: A write of enable 1 while the flag is set, following enable 0, raises `nmi_req_o` again after the write edge; repeated 0-to-1 toggles in one blanking period each produce a new rising edge.
- R4: During a cycle with `stat_rd_i` high, `stat_vbl_o` shows the flag value before the read; after that edge the flag is 0, and later enable toggles in the same period leave `nmi_req_o` at 0.
- R5: When the inputs present line CLR_LINE (default 261) and dot EDGE_DOT at a clock edge, the flag and `nmi_req_o` are 0 after that edge.
- R6: `ctl_nmi_en_i` is stored only in cycles with `ctl_wr_i` high; in all other cycles its value has no effect on `nmi_req_o`.
- R7: If a status read falls in the same cycle as the set position, the read returns 0 and the flag is still set after that edge.
- R8: After reset, the flag, the enable bit, `nmi_req_o` and `stat_vbl_o` are all 0.
- R9: Writing enable 0 while the flag is set drops `nmi_req_o` after the write edge, and the flag stays 1.
- R10: `stat_vbl_o` is 0 in cycles without `stat_rd_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_line_i | input | LINE_W | Current scanline number |
| scan_dot_i | input | DOT_W | Current dot within the scanline |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_nmi_en_i | input | 1 | Bit 7 of the written control value (NMI enable) |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_vbl_o | output | 1 | Status bit 7 read data (flag before any clear by this read) |
| vblank_o | output | 1 | Current vertical blank flag |
| nmi_req_o | output | 1 | NMI request level, active high |

## Verification
A status read can land on the exact cycle in which the set position arrives. In that case the rule that clears the flag and the rule that sets it act in the same cycle. The bench drives the set position and the read strobe together. It expects read data 0 and a flag of 1 after the edge, with the NMI following if the enable bit is set. It also places enable writes before and after reads within one blanking period to separate the retrigger path from the blocked state.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
    localparam int LINE_W    = 9;
    localparam int DOT_W     = 9;
    localparam int SET_LINE  = 241;
    localparam int CLR_LINE  = 261;
    localparam int EDGE_DOT  = 1;

    typedef struct packed {
        logic flag;
    } vbl_state_t;

    typedef struct packed {
        logic en;
    } nmi_state_t;
endpackage

// File: rtl/vbl_event_decode.sv
module vbl_event_decode #(
    parameter int LINE_W   = vbl_pkg::LINE_W,
    parameter int DOT_W    = vbl_pkg::DOT_W,
    parameter int SET_LINE = vbl_pkg::SET_LINE,
    parameter int CLR_LINE = vbl_pkg::CLR_LINE,
    parameter int EDGE_DOT = vbl_pkg::EDGE_DOT
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [DOT_W-1:0]  dot_i,
    output logic              set_o,
    output logic              clr_o
);
    localparam logic [LINE_W-1:0] SET_L = LINE_W'(SET_LINE);
    localparam logic [LINE_W-1:0] CLR_L = LINE_W'(CLR_LINE);
    localparam logic [DOT_W-1:0]  EDGE_D = DOT_W'(EDGE_DOT);

    logic at_edge;

    always_comb begin
        at_edge = (dot_i == EDGE_D);
        set_o   = at_edge && (line_i == SET_L);
        clr_o   = at_edge && (line_i == CLR_L);
    end
endmodule

// File: rtl/vbl_flag_reg.sv
module vbl_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic rd_i,
    output logic flag_o,
    output logic rd_data_o
);
    import vbl_pkg::*;

    vbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i || rd_i) st_d.flag = 1'b0;
        if (set_i)         st_d.flag = 1'b1;   // set wins over a same-cycle read
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o    = st_q.flag;
    assign rd_data_o = rd_i & st_q.flag;

    a_r1_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !set_i) |=> !flag_o);
    a_r5_preline_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/nmi_gate.sv
module nmi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic en_data_i,
    input  logic flag_i,
    output logic en_o,
    output logic nmi_o
);
    import vbl_pkg::*;

    nmi_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.en = en_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign nmi_o = st_q.en & flag_i;

    a_r6_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o));
    a_r3_enable_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_o == $past(en_data_i)));
endmodule

// File: rtl/vblank_nmi_top.sv
module vblank_nmi_top #(
    parameter int LINE_W   = vbl_pkg::LINE_W,
    parameter int DOT_W    = vbl_pkg::DOT_W,
    parameter int SET_LINE = vbl_pkg::SET_LINE,
    parameter int CLR_LINE = vbl_pkg::CLR_LINE,
    parameter int EDGE_DOT = vbl_pkg::EDGE_DOT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] scan_line_i,
    input  logic [DOT_W-1:0]  scan_dot_i,
    input  logic              ctl_wr_i,
    input  logic              ctl_nmi_en_i,
    input  logic              stat_rd_i,
    output logic              stat_vbl_o,
    output logic              vblank_o,
    output logic              nmi_req_o
);
    logic set_evt, clr_evt, en_q;

    vbl_event_decode #(
        .LINE_W(LINE_W), .DOT_W(DOT_W), .SET_LINE(SET_LINE),
        .CLR_LINE(CLR_LINE), .EDGE_DOT(EDGE_DOT)
    ) u_dec (
        .line_i(scan_line_i), .dot_i(scan_dot_i),
        .set_o(set_evt), .clr_o(clr_evt)
    );

    vbl_flag_reg u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(set_evt), .clr_i(clr_evt),
        .rd_i(stat_rd_i), .flag_o(vblank_o), .rd_data_o(stat_vbl_o)
    );

    nmi_gate u_gate (
        .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr_i), .en_data_i(ctl_nmi_en_i),
        .flag_i(vblank_o), .en_o(en_q), .nmi_o(nmi_req_o)
    );

    // R4: after a read (not racing the set position) no request can remain
    a_r4_read_blocks_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !set_evt) |=> !nmi_req_o);
    // R2: with enable held high, the set position raises the request
    a_r2_nmi_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && en_q && !ctl_wr_i) |=> nmi_req_o);
    // R5: the pre-render position leaves no request behind
    a_r5_no_nmi_preline: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !nmi_req_o);
endmodule

// File: tb/sim_vblank_nmi_top.sv
module sim_vblank_nmi_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] line = '0;
    logic [8:0] dot = '0;
    logic       wr = 1'b0, en_d = 1'b0, rd = 1'b0;
    logic       stat_vbl, vblank, nmi;
    int         checks = 0, fails = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vblank_nmi_top u0 (
        .clk(clk), .rst_n(rst_n), .scan_line_i(line), .scan_dot_i(dot),
        .ctl_wr_i(wr), .ctl_nmi_en_i(en_d), .stat_rd_i(rd),
        .stat_vbl_o(stat_vbl), .vblank_o(vblank), .nmi_req_o(nmi)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // drive one cycle of stimulus, return 1 time unit after the edge
    task automatic step(int l, int d, bit w, bit e, bit r);
        @(negedge clk);
        line = 9'(l); dot = 9'(d); wr = w; en_d = e; rd = r;
        @(posedge clk); #1;
        wr = 0; rd = 0;
    endtask

    task automatic t_reset();
        chk("R8 flag", vblank, 0);
        chk("R8 nmi", nmi, 0);
        chk("R8 stat", stat_vbl, 0);
    endtask

    task automatic t_set_disabled();
        step(240, 340, 0, 0, 0); chk("R1 before", vblank, 0);
        step(241, 0, 0, 0, 0);   chk("R1 dot0", vblank, 0);
        step(241, 1, 0, 0, 0);   chk("R1 set", vblank, 1);
        chk("R2 disabled", nmi, 0);
        chk("R10 no read", stat_vbl, 0);
    endtask

    task automatic t_toggle();
        step(245, 10, 1, 1, 0); chk("R3 enable", nmi, 1);
        step(245, 20, 1, 0, 0); chk("R9 drop", nmi, 0);
        chk("R9 flag kept", vblank, 1);
        step(246, 5, 1, 1, 0);  chk("R3 retrigger", nmi, 1);
        step(246, 9, 0, 0, 0);  chk("R6 ignored", nmi, 1);
    endtask

    task automatic t_read();
        @(negedge clk);
        line = 250; dot = 10; rd = 1; #1;
        chk("R4 read data", stat_vbl, 1);
        @(posedge clk); #1; rd = 0;
        chk("R4 cleared", vblank, 0);
        chk("R4 nmi", nmi, 0);
        step(251, 0, 1, 0, 0);
        step(251, 4, 1, 1, 0);  chk("R4 blocked", nmi, 0);
    endtask

    task automatic t_frame();
        step(241, 1, 0, 0, 0);  chk("R2 set with en", nmi, 1);
        step(260, 300, 0, 0, 0); chk("R5 before", vblank, 1);
        step(261, 1, 0, 0, 0);  chk("R5 clear", vblank, 0);
        chk("R5 nmi", nmi, 0);
        step(10, 3, 1, 0, 0);   step(10, 4, 1, 1, 0);
        chk("R3 outside", nmi, 0);
    endtask

    task automatic t_race();
        @(negedge clk);
        line = 241; dot = 1; rd = 1; #1;
        chk("R7 read data", stat_vbl, 0);
        @(posedge clk); #1; rd = 0;
        chk("R7 flag", vblank, 1);
        chk("R7 nmi", nmi, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; t_reset();
        @(negedge clk); rst_n = 1;
        t_set_disabled();
        t_toggle();
        t_read();
        t_frame();
        t_race();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule